// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block moves a small processor core between three operating modes: running, idle and sleep. The core raises a one-cycle sleep-instruction strobe. A mode-select bit decides whether that strobe stops only the CPU clock (idle) or also stops the oscillator (sleep). The block drives three enables: the CPU clock, the peripheral clock and the oscillator. It also drives a one-cycle resume pulse, with a flag that tells the core whether to service an interrupt before it continues at the instruction after the sleep instruction.

Idle ends on any enabled interrupt request. Sleep ends only through the active-low sleep pin or through reset. The pin is sampled through a two-flop synchronizer. It is treated as level sensitive or as edge sensitive, as chosen by a wake-select bit that is captured when sleep is entered. After a wake from sleep, the oscillator runs for a parameterized warm-up time before the CPU clock comes back. The block clock is treated as always running.

Top module: `lpm_seq_top`

## Requirements
- R1: While rst_n is low, and from then until the first strobe, cpu_clk_en, per_clk_en and osc_en are 1 and resume_pulse and resume_irq are 0. Driving rst_n low returns the block from idle or sleep to this running state at once.
- R2: In the running mode, slp_req=1 with mode_sel=0 enters idle from the next cycle. In idle cpu_clk_en is 0 while per_clk_en and osc_en stay 1.
- R3: In idle, any bit of irq_vec at 1 at a clock edge returns the block to running at that edge. resume_pulse is 1 for that one cycle, and resume_irq equals irq_en as sampled at that edge.
- R4: In the running mode, slp_req=1 with mode_sel=1 enters sleep from the next cycle, provided the wake-select bit allows it (R5). In sleep all three enables are 0.
- R5: With wake_edge=0 (level sensitive), a sleep request is ignored when the synchronized sleep pin is high: all outputs stay at their running values.
- R6: In level-sensitive sleep, the synchronized pin at high causes a wake. The pin must be high before two clock edges for the wake to be seen at the second edge.
- R7: With wake_edge=1 (edge sensitive), sleep is entered whatever the pin level is. Only a falling edge of the synchronized pin that is seen while in sleep wakes the block. A steady level or a rising edge has no effect.
- R8: After a sleep wake, osc_en is 1 and cpu_clk_en and per_clk_en are 0 for WARM_CYC cycles. The block then returns to running with a one-cycle resume_pulse and resume_irq=0.
- R9: In sleep irq_vec has no effect. In idle the sleep pin has no effect. slp_req has no effect outside the running mode.
- R10: resume_pulse is never 1 in two consecutive cycles, and it is 1 only in the first running cycle after idle or warm-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slp_req | input | 1 | One-cycle sleep-instruction strobe from the core |
| mode_sel | input | 1 | 1 selects sleep, 0 selects idle |
| wake_edge | input | 1 | 1: pin wake on falling edge; 0: pin wake on high level |
| sleep_pin_n | input | 1 | Asynchronous active-low sleep pin |
| irq_vec | input | N_IRQ | Enabled interrupt requests (watchdog, external and internal sources) |
| irq_en | input | 1 | Global interrupt enable of the core |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| resume_pulse | output | 1 | One-cycle pulse when execution resumes |
| resume_irq | output | 1 | With resume_pulse: 1 services the interrupt first |

## Verification
On every cycle the assertions check that the enables stay ordered (a CPU clock never runs without the peripheral clock and oscillator), that an idle-mode interrupt wakes the block with the correct resume flag, that sleep requests are either taken or refused according to the synchronized pin level, and that the resume pulse is a single cycle. The warm-up length, the synchronizer latency, the edge-versus-level wake choice latched at entry, and the requirement that inputs have no effect in the wrong mode can be shown only by the bench's scenarios. These scenarios compare every cycle against a behavioural model.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_IDLE  = 2'd1,
        MODE_SLEEP = 2'd2,
        MODE_WARM  = 2'd3
    } lpm_mode_e;

    typedef struct packed {
        lpm_mode_e mode;
        logic      edge_wake;
        logic      resume;
        logic      take_irq;
    } lpm_fsm_t;
endpackage

// File: rtl/lpm_pin_sync.sv
module lpm_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_lvl,
    output logic pin_fall
);
    localparam int W = STAGES + 1;

    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[W-2:0], pin_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign pin_lvl  = sh_q[STAGES-1];
    assign pin_fall = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/lpm_warm_timer.sv
module lpm_warm_timer #(
    parameter int WARM_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = (WARM_CYC < 2) ? 1 : $clog2(WARM_CYC);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (start) begin
            t_d.run = 1'b1;
            t_d.cnt = CW'(WARM_CYC - 1);
        end else if (t_q.run) begin
            if (t_q.cnt == '0) t_d.run = 1'b0;
            else               t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign done = t_q.run && (t_q.cnt == '0);
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
    import lpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      slp_req,
    input  logic      mode_sel,
    input  logic      wake_edge,
    input  logic      pin_lvl,
    input  logic      pin_fall,
    input  logic      irq_any,
    input  logic      irq_en,
    input  logic      warm_done,
    output lpm_mode_e mode,
    output logic      warm_start,
    output logic      resume,
    output logic      take_irq
);
    lpm_fsm_t st_d, st_q;
    logic     pin_wake;

    always_comb begin
        st_d          = st_q;
        st_d.resume   = 1'b0;
        st_d.take_irq = 1'b0;
        warm_start    = 1'b0;
        pin_wake      = st_q.edge_wake ? pin_fall : pin_lvl;
        unique case (st_q.mode)
            MODE_RUN: begin
                if (slp_req) begin
                    if (!mode_sel) begin
                        st_d.mode = MODE_IDLE;
                    end else if (wake_edge || !pin_lvl) begin
                        st_d.mode      = MODE_SLEEP;
                        st_d.edge_wake = wake_edge;
                    end
                end
            end
            MODE_IDLE: begin
                if (irq_any) begin
                    st_d.mode     = MODE_RUN;
                    st_d.resume   = 1'b1;
                    st_d.take_irq = irq_en;
                end
            end
            MODE_SLEEP: begin
                if (pin_wake) begin
                    st_d.mode  = MODE_WARM;
                    warm_start = 1'b1;
                end
            end
            MODE_WARM: begin
                if (warm_done) begin
                    st_d.mode   = MODE_RUN;
                    st_d.resume = 1'b1;
                end
            end
            default: st_d.mode = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_RUN, edge_wake: 1'b0, resume: 1'b0, take_irq: 1'b0};
        else        st_q <= st_d;
    end

    assign mode     = st_q.mode;
    assign resume   = st_q.resume;
    assign take_irq = st_q.take_irq;
endmodule

// File: rtl/lpm_seq_top.sv
module lpm_seq_top
    import lpm_pkg::*;
#(
    parameter int N_IRQ    = 4,
    parameter int WARM_CYC = 16,
    parameter int SYNC_STG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slp_req,
    input  logic             mode_sel,
    input  logic             wake_edge,
    input  logic             sleep_pin_n,
    input  logic [N_IRQ-1:0] irq_vec,
    input  logic             irq_en,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             osc_en,
    output logic             resume_pulse,
    output logic             resume_irq
);
    logic      pin_lvl, pin_fall, warm_start, warm_done, resume, take_irq;
    lpm_mode_e mode;

    lpm_pin_sync #(.STAGES(SYNC_STG)) sync_i (
        .clk(clk), .rst_n(rst_n), .pin_n(sleep_pin_n),
        .pin_lvl(pin_lvl), .pin_fall(pin_fall)
    );

    lpm_warm_timer #(.WARM_CYC(WARM_CYC)) tmr_i (
        .clk(clk), .rst_n(rst_n), .start(warm_start), .done(warm_done)
    );

    lpm_mode_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .slp_req(slp_req), .mode_sel(mode_sel),
        .wake_edge(wake_edge), .pin_lvl(pin_lvl), .pin_fall(pin_fall),
        .irq_any(|irq_vec), .irq_en(irq_en), .warm_done(warm_done),
        .mode(mode), .warm_start(warm_start), .resume(resume), .take_irq(take_irq)
    );

    assign cpu_clk_en   = (mode == MODE_RUN);
    assign per_clk_en   = (mode == MODE_RUN) || (mode == MODE_IDLE);
    assign osc_en       = (mode != MODE_SLEEP);
    assign resume_pulse = resume;
    assign resume_irq   = resume & take_irq;
endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk #(
    parameter int N_IRQ = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             slp_req,
    input logic             mode_sel,
    input logic             wake_edge,
    input logic [N_IRQ-1:0] irq_vec,
    input logic             irq_en,
    input logic             cpu_clk_en,
    input logic             per_clk_en,
    input logic             osc_en,
    input logic             resume_pulse,
    input logic             resume_irq,
    input logic             pin_lvl
);
    // R2
    enable_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en |-> per_clk_en) and (per_clk_en |-> osc_en));

    // R3
    idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_clk_en && per_clk_en && (|irq_vec))
        |=> (cpu_clk_en && resume_pulse && (resume_irq == $past(irq_en))));

    // R4
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && slp_req && mode_sel && (wake_edge || !pin_lvl)) |=> !osc_en);

    // R5
    level_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && slp_req && mode_sel && !wake_edge && pin_lvl) |=> cpu_clk_en);

    // R8
    warm_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_en) |-> (!cpu_clk_en && !per_clk_en));

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |=> !resume_pulse);

    // R10
    pulse_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |-> (cpu_clk_en && !$past(cpu_clk_en)));
endmodule

bind lpm_seq_top lpm_seq_chk #(.N_IRQ(N_IRQ)) chk_i (
    .clk(clk), .rst_n(rst_n), .slp_req(slp_req), .mode_sel(mode_sel),
    .wake_edge(wake_edge), .irq_vec(irq_vec), .irq_en(irq_en),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .resume_pulse(resume_pulse), .resume_irq(resume_irq), .pin_lvl(pin_lvl)
);

// File: tb/lpm_seq_tb.sv
`timescale 1ns/1ps
module lpm_seq_top_tb_top;
    localparam int N_IRQ = 4;
    localparam int WARM  = 16;

    logic clk = 0, rst_n = 0;
    logic slp_req = 0, mode_sel = 0, wake_edge = 0, sleep_pin_n = 1, irq_en = 0;
    logic [N_IRQ-1:0] irq_vec = '0;
    logic cpu_clk_en, per_clk_en, osc_en, resume_pulse, resume_irq;

    always #2 clk = ~clk;

    lpm_seq_top #(.N_IRQ(N_IRQ), .WARM_CYC(WARM)) dut_i (
        .clk(clk), .rst_n(rst_n), .slp_req(slp_req), .mode_sel(mode_sel),
        .wake_edge(wake_edge), .sleep_pin_n(sleep_pin_n), .irq_vec(irq_vec),
        .irq_en(irq_en), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .osc_en(osc_en), .resume_pulse(resume_pulse), .resume_irq(resume_irq)
    );

    // Behavioural reference: 0 run, 1 idle, 2 sleep, 3 warm-up
    int m_mode, m_left, m_res, m_tk, m_edge;
    int pq[$];
    int n_cmp = 0, n_bad = 0;
    string cur_req = "R1";
    bit done = 0;

    always @(posedge clk or negedge rst_n) begin
        int lvl, fall;
        if (!rst_n) begin
            m_mode = 0; m_left = 0; m_res = 0; m_tk = 0; m_edge = 0;
            pq = '{1, 1, 1};
        end else begin
            lvl  = pq[1];
            fall = (pq[2] == 1 && pq[1] == 0) ? 1 : 0;
            m_res = 0; m_tk = 0;
            case (m_mode)
                0: if (slp_req) begin
                       if (!mode_sel) m_mode = 1;
                       else if (wake_edge || lvl == 0) begin m_mode = 2; m_edge = wake_edge; end
                   end
                1: if (irq_vec != 0) begin m_mode = 0; m_res = 1; m_tk = irq_en; end
                2: if (m_edge ? fall : lvl) begin m_mode = 3; m_left = WARM; end
                default: begin
                    m_left--;
                    if (m_left == 0) begin m_mode = 0; m_res = 1; end
                end
            endcase
            pq.push_front(int'(sleep_pin_n));
            void'(pq.pop_back());
        end
    end

    task automatic cmp(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (!done) begin
        cmp(cur_req, "cpu_clk_en", cpu_clk_en, m_mode == 0);
        cmp(cur_req, "per_clk_en", per_clk_en, m_mode <= 1);
        cmp(cur_req, "osc_en", osc_en, m_mode != 2);
        cmp(cur_req, "resume_pulse", resume_pulse, m_res);
        cmp(cur_req, "resume_irq", resume_irq, m_tk);
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic strobe(logic sel, logic edg);
        slp_req = 1; mode_sel = sel; wake_edge = edg;
        step(1);
        slp_req = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++; n_cmp++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        // R1: reset values and the running state after release
        cur_req = "R1";
        step(3); rst_n = 1; step(3);
        cmp("R1", "running after reset", cpu_clk_en & per_clk_en & osc_en, 1);

        // R2 and R3: idle entry, then interrupt wakes with irq_en=1
        cur_req = "R2"; strobe(0, 0); step(4);
        // R9: pin activity and strobes in idle are ignored
        cur_req = "R9"; sleep_pin_n = 0; step(3); sleep_pin_n = 1; strobe(1, 1); step(3);
        cmp("R9", "still idle", per_clk_en & ~cpu_clk_en, 1);
        cur_req = "R3"; irq_en = 1; irq_vec = 4'b0100; step(1); irq_vec = 0; step(3);
        // R3: idle wake with interrupts disabled
        cur_req = "R3"; irq_en = 0; strobe(0, 0); step(2);
        irq_vec = 4'b1000; step(1); irq_vec = 0; step(3);

        // R5: level mode, pin high, request refused
        cur_req = "R5"; strobe(1, 0); step(3);
        cmp("R5", "sleep refused", cpu_clk_en, 1);
        // R4: level mode entry with pin low
        cur_req = "R4"; sleep_pin_n = 0; step(3); strobe(1, 0); step(3);
        cmp("R4", "sleep entered", osc_en, 0);
        // R9: interrupts ignored in sleep
        cur_req = "R9"; irq_en = 1; irq_vec = 4'b1111; step(4); irq_vec = 0; irq_en = 0;
        // R6: level wake, then R8 warm-up
        cur_req = "R6"; sleep_pin_n = 1; step(3);
        cur_req = "R8"; step(WARM + 4);
        cmp("R8", "back to running", cpu_clk_en, 1);

        // R7: edge mode entered with pin high; steady high does not wake
        cur_req = "R7"; strobe(1, 1); step(10);
        cmp("R7", "still asleep", osc_en, 0);
        sleep_pin_n = 0; step(3);
        cur_req = "R8"; step(WARM + 3);
        // R7: pin low at entry, rising edge no wake, falling edge wakes
        cur_req = "R7"; strobe(1, 1); step(3); sleep_pin_n = 1; step(6);
        cmp("R7", "rise ignored", osc_en, 0);
        sleep_pin_n = 0; step(1); sleep_pin_n = 1; step(3);
        cur_req = "R8"; step(WARM + 3);

        // R1: reset from sleep and from idle
        cur_req = "R1"; sleep_pin_n = 0; step(3); strobe(1, 0); step(3);
        rst_n = 0; step(2); rst_n = 1; step(3);
        cmp("R1", "reset left sleep", cpu_clk_en, 1);
        strobe(0, 0); step(3); rst_n = 0; step(2); rst_n = 1; step(3);
        cmp("R1", "reset left idle", cpu_clk_en, 1);

        // R10: back-to-back idle cycles, resume pulses stay single
        cur_req = "R10";
        for (int i = 0; i < 3; i++) begin
            strobe(0, 0); irq_vec = 4'b0001; irq_en = i[0]; step(1); irq_vec = 0; step(2);
        end
        step(2);
        finish_run();
    end
endmodule